// File: doc/BRIEF.md
# Carry-Propagate Mask Unit

The unit takes a propagate mask and a generate mask, one bit of each per bit position, and returns the mask of positions that receive a carry. The result resolves carries between the words of a big-integer addition. It also serves as a predicate-mask operation, where a carry that runs through a stretch of propagate bits marks every lane it reaches. The chain is not built as a lookahead tree. One binary addition, ((P | G) + G + cin) XOR P, produces it, and the carry-in enters at the bottom of that sum.

A radix code splits the word into independent segments of 8, 16, 32 or 64 bits. No carry crosses a segment edge, and every segment starts from the same carry-in. The carry-in is taken from one of two flag inputs, picked by a mode pin: the plain carry flag or the vector summary flag. The carry that leaves the most significant bit comes out as a carry flag and again as a duplicate end-bit flag. A zero flag reports an all-zero mask.

Operands enter on a valid/ready stream and results leave on another, one cycle after acceptance. The unit holds exactly one result. A new operand set is accepted while the output slot is empty, or in the same cycle that the held result is taken. While `out_valid` is high and `out_ready` is low, the result and all flags stay frozen and `in_ready` is low.

Top module: `cpm_mask_unit`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An operand set accepted on a clock edge (`in_valid` and `in_ready` both high) is presented with `out_valid` high after that edge.
- R2: After reset `out_valid` is low. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_mask`, `out_carry`, `out_ge` and `out_zero` hold their values on the next cycle.
- R3: Bit i of `out_mask` equals c[i] XOR (P[i] AND G[i]). Here c[i] is the carry into bit i, c[i+1] = G[i] OR (P[i] AND c[i]), and c at the lowest bit of a segment is the selected carry-in. This equals ((P|G)+G+cin) XOR P evaluated per segment.
- R4: `in_radix` sets the segment width: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. Segments are aligned to bit 0. No carry passes from one segment into the next, and each segment starts from the same carry-in.
- R5: The carry-in is `ca_flag_in` when `in_vec_mode` is 0 and `so_flag_in` when `in_vec_mode` is 1.
- R6: `out_carry` is the carry leaving bit 63, the top bit of the most significant segment. `out_ge` always equals `out_carry`.
- R7: `out_zero` is high exactly when `out_mask` is all zeros.
- R8: With P and G both zero and a carry-in of 0, the mask is all zeros, `out_carry` is 0 and `out_zero` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Unit can accept an operand set |
| in_prop | input | 64 | Propagate mask P |
| in_gen | input | 64 | Generate mask G |
| in_radix | input | 2 | Segment width code |
| in_vec_mode | input | 1 | Carry-in source select |
| ca_flag_in | input | 1 | Carry flag, used as carry-in in scalar mode |
| so_flag_in | input | 1 | Summary flag, used as carry-in in vector mode |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_mask | output | 64 | Carry mask |
| out_carry | output | 1 | Carry out of the top bit |
| out_ge | output | 1 | End-bit flag, copy of the carry out |
| out_zero | output | 1 | Mask is all zeros |

## Verification
The bench targets the cases where a carry would travel farthest or would cross a segment edge. All-propagate with a carry-in of 1 should fill every segment. A unit that lets carries cross segment edges, or that feeds the carry-in only to the lowest segment, gives a wrong mask at radix 0 to 2. All-generate with no propagate shows whether the lowest bit of each segment takes the carry-in or a stale carry. Patterns with P and G set on the same bit catch the XOR with P being dropped. Mode flips with opposite flag values expose a swapped carry-in source, and random stalls on the output expose a result that changes or is lost while it waits.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int SLICE_W = 8;

  typedef enum logic [1:0] {
    SEG8  = 2'd0,
    SEG16 = 2'd1,
    SEG32 = 2'd2,
    SEG64 = 2'd3
  } seg_mode_e;
endpackage

// File: rtl/cpm_slice.sv
// One adder slice: ((P|G) + G + cin) ^ P over W bits.
module cpm_slice #(
  parameter int W = 8
) (
  input  logic [W-1:0] prop,
  input  logic [W-1:0] gen,
  input  logic         cin,
  output logic [W-1:0] cmask,
  output logic         cout
);
  logic [W:0] total;

  assign total = {1'b0, prop | gen} + {1'b0, gen} + {{W{1'b0}}, cin};
  assign cmask = total[W-1:0] ^ prop;
  assign cout  = total[W];
endmodule

// File: rtl/cpm_chain.sv
// Chain of slices; the radix decides which slice edges cut the carry.
module cpm_chain
  import cpm_pkg::*;
#(
  parameter int WIDTH   = 64,
  parameter int SLICE   = SLICE_W
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] gen,
  input  seg_mode_e        radix,
  input  logic             cin,
  output logic [WIDTH-1:0] mask,
  output logic             cout,
  output logic             zero
);
  localparam int NSLICE = WIDTH / SLICE;

  logic [NSLICE:0]   link;
  logic [NSLICE-1:0] slice_cin;
  logic [2:0]        grp_lo;

  // low slice-index bits that must be zero at a segment start
  assign grp_lo  = 3'((4'd1 << radix) - 4'd1);
  assign link[0] = cin;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    localparam logic [2:0] KLO = 3'(k % 8);
    assign slice_cin[k] = ((KLO & grp_lo) == 3'd0) ? cin : link[k];

    cpm_slice #(.W(SLICE)) u_slice (
      .prop  (prop[k*SLICE +: SLICE]),
      .gen   (gen[k*SLICE +: SLICE]),
      .cin   (slice_cin[k]),
      .cmask (mask[k*SLICE +: SLICE]),
      .cout  (link[k+1])
    );
  end

  assign cout = link[NSLICE];
  assign zero = ~|mask;
endmodule

// File: rtl/cpm_mask_unit.sv
module cpm_mask_unit
  import cpm_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_prop,
  input  logic [WIDTH-1:0] in_gen,
  input  logic [1:0]       in_radix,
  input  logic             in_vec_mode,
  input  logic             ca_flag_in,
  input  logic             so_flag_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_mask,
  output logic             out_carry,
  output logic             out_ge,
  output logic             out_zero
);
  logic             accept;
  logic             cin_sel;
  logic [WIDTH-1:0] mask_d;
  logic             cout_d;
  logic             zero_d;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign cin_sel  = in_vec_mode ? so_flag_in : ca_flag_in;

  cpm_chain #(.WIDTH(WIDTH), .SLICE(SLICE_W)) u_chain (
    .prop  (in_prop),
    .gen   (in_gen),
    .radix (seg_mode_e'(in_radix)),
    .cin   (cin_sel),
    .mask  (mask_d),
    .cout  (cout_d),
    .zero  (zero_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_carry <= 1'b0;
      out_ge    <= 1'b0;
      out_zero  <= 1'b1;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_mask  <= mask_d;
        out_carry <= cout_d;
        out_ge    <= cout_d;
        out_zero  <= zero_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cpm_mask_unit_chk.sv
module cpm_mask_unit_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_prop,
  input logic [WIDTH-1:0] in_gen,
  input logic             in_vec_mode,
  input logic             ca_flag_in,
  input logic             so_flag_in,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_mask,
  input logic             out_carry,
  input logic             out_ge,
  input logic             out_zero
);
  p_accept_shows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_stall_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mask) &&
                                   $stable(out_carry) && $stable(out_zero)));

  p_ge_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ge == out_carry));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zero == (out_mask == '0)));

  p_quiet_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_prop == '0 && in_gen == '0 &&
     !(in_vec_mode ? so_flag_in : ca_flag_in))
    |=> (out_mask == '0 && !out_carry && out_zero));
endmodule

bind cpm_mask_unit cpm_mask_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_prop(in_prop), .in_gen(in_gen), .in_vec_mode(in_vec_mode),
  .ca_flag_in(ca_flag_in), .so_flag_in(so_flag_in), .out_valid(out_valid),
  .out_ready(out_ready), .out_mask(out_mask), .out_carry(out_carry),
  .out_ge(out_ge), .out_zero(out_zero)
);

// File: tb/cpm_mask_unit_test.sv
`timescale 1ns/1ps
module cpm_mask_unit_test;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_prop = '0;
  logic [W-1:0] in_gen = '0;
  logic [1:0]   in_radix = 2'd0;
  logic         in_vec_mode = 1'b0;
  logic         ca_flag_in = 1'b0;
  logic         so_flag_in = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_mask;
  logic         out_carry;
  logic         out_ge;
  logic         out_zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit stall_mode = 1'b0;

  logic [W:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  cpm_mask_unit #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_prop(in_prop), .in_gen(in_gen), .in_radix(in_radix),
    .in_vec_mode(in_vec_mode), .ca_flag_in(ca_flag_in),
    .so_flag_in(so_flag_in), .out_valid(out_valid), .out_ready(out_ready),
    .out_mask(out_mask), .out_carry(out_carry), .out_ge(out_ge),
    .out_zero(out_zero)
  );

  // bit-serial reference: returns {carry_out, mask}
  function automatic logic [W:0] model(logic [W-1:0] p, logic [W-1:0] g,
                                       int radix, logic cin);
    logic [W-1:0] m;
    logic c;
    int seg;
    seg = 8 << radix;
    c = cin;
    for (int i = 0; i < W; i++) begin
      if (i % seg == 0) c = cin;
      m[i] = c ^ (p[i] & g[i]);
      c = g[i] | (p[i] & c);
    end
    return {c, m};
  endfunction

  task automatic check(bit ok, string req, string what, logic [W-1:0] act,
                       logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor, sampling at the falling edge
  logic         prev_stall = 1'b0;
  logic [W-1:0] prev_mask;
  logic         prev_carry, prev_zero;
  always @(negedge clk) begin
    if (rst_n) begin
      check(in_ready == (!out_valid || out_ready), "R1", "in_ready",
            W'(in_ready), W'(!out_valid || out_ready));
      if (prev_stall) begin
        check(out_valid && out_mask == prev_mask && out_carry == prev_carry &&
              out_zero == prev_zero, "R2", "held result", out_mask, prev_mask);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected result", out_mask, '0);
        end else begin
          logic [W:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_mask == e[W-1:0], t, "mask", out_mask, e[W-1:0]);
          check(out_carry == e[W], "R6", "carry", W'(out_carry), W'(e[W]));
          check(out_ge == e[W], "R6", "ge", W'(out_ge), W'(e[W]));
          check(out_zero == (e[W-1:0] == '0), "R7", "zero", W'(out_zero),
                W'(e[W-1:0] == '0));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_mask  = out_mask;
      prev_carry = out_carry;
      prev_zero  = out_zero;
      if (in_valid && in_ready) begin
        exp_q.push_back(model(in_prop, in_gen, int'(in_radix),
                              in_vec_mode ? so_flag_in : ca_flag_in));
      end
    end
  end

  // consumer back-pressure
  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  task automatic send(logic [W-1:0] p, logic [W-1:0] g, int radix, bit vec,
                      bit ca, bit so, string tag);
    in_prop = p;
    in_gen = g;
    in_radix = 2'(radix);
    in_vec_mode = vec;
    ca_flag_in = ca;
    so_flag_in = so;
    in_valid = 1'b1;
    tag_q.push_back(tag);
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R2", "valid after reset", W'(out_valid), '0);
    @(posedge clk);
    #1;

    // R8: nothing to propagate
    send('0, '0, 3, 0, 0, 1, "R8");
    // R3/R4: all-propagate with carry-in, every radix
    for (int r = 0; r < 4; r++) send('1, '0, r, 0, 1, 0, "R3/R4");
    // R4: all-generate, carry-in 0 then 1
    for (int r = 0; r < 4; r++) begin
      send('0, '1, r, 0, 0, 0, "R4");
      send('0, '1, r, 1, 0, 1, "R4");
    end
    // R5: source select with opposite flags
    send({W{1'b1}} >> 4, '0, 3, 0, 1, 0, "R5");
    send({W{1'b1}} >> 4, '0, 3, 1, 1, 0, "R5");
    send('1, '0, 1, 1, 0, 1, "R5");
    send('1, '0, 1, 0, 0, 1, "R5");
    // R3: overlapping P and G, a single generate feeding a long run
    send('1, '1, 2, 0, 0, 0, "R3");
    send(64'hFFFF_FFFF_FFFF_FFFE, 64'h1, 3, 0, 0, 0, "R3");
    send(64'h00FF_00FF_FFFF_FF00, 64'h0000_0100_0000_0080, 0, 0, 1, 0, "R3");

    // random traffic, first free-flowing then with a stalling consumer
    for (int n = 0; n < 400; n++) begin
      if (n == 200) stall_mode = 1'b1;
      send({$urandom, $urandom}, {$urandom, $urandom} & {$urandom, $urandom},
           $urandom % 4, 1'($urandom), 1'($urandom), 1'($urandom), "R3/R4/R5");
    end
    stall_mode = 1'b1;
    for (int n = 0; n < 30; n++)
      send('1, 64'h1, $urandom % 4, 0, 0, 0, "R2/R4");
    stall_mode = 1'b0;

    repeat (10) @(posedge clk);
    check(exp_q.size() == 0, "R1", "results outstanding",
          W'(exp_q.size()), '0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule